// File: doc/BRIEF.md
# Keyed ROM Read Descrambler

This block sits between a processor's instruction/data fetch path and an external 32-bit program ROM. Each word read is forwarded to the ROM unchanged. The word that comes back is XORed with a key taken from a 256-entry table, and the result is returned to the requester. The key is chosen by the low eight bits of the word address, so addresses 256 words apart share a key.

Software fills the key table at run time through a small write window. Only the least significant byte lane of each write is used. The stored byte is expanded into a 32-bit key that has the byte in bit positions 31:24 and 15:8 and zeros elsewhere. As a result, only those two bytes of each ROM word are ever altered. After reset every key is zero, so the ROM reads back in clear until the table is loaded.

The key table is read synchronously. The key is then delayed so that it meets the ROM data, which returns a fixed number of cycles after the request.

Top module: `rom_key_descrambler`

## Requirements
- R1: In the cycle a read is requested (`rd_en` high), `rom_en` is high and `rom_addr` equals `rd_addr`.
- R2: Each request yields exactly one cycle of `rd_valid`, exactly `ROM_LAT` cycles after the request. `rd_valid` is never high at any other time.
- R3: When `rd_valid` is high, `rd_data` equals `rom_data ^ {k, 8'h00, k, 8'h00}`, where k is the key byte of entry `rd_addr[7:0]` of the request. Bits 23:16 and 7:0 of the ROM word are never changed.
- R4: After reset every key byte is zero, so `rd_data` equals `rom_data` until a key is written.
- R5: A key write is a cycle with `key_wr_en` high and `key_wr_be[0]` high. It stores `key_wr_data[7:0]` into the entry selected by `key_wr_addr[9:2]`. Bits 31:8 of `key_wr_data` have no effect.
- R6: A key write cycle with `key_wr_be[0]` low leaves the table unchanged. `key_wr_addr[1:0]` does not affect which entry is written.
- R7: The key is selected by `rd_addr[7:0]` only. Word addresses that differ only above bit 7, up to the top of the `2**ADDR_W`-word window, use the same key.
- R8: If a key write and a read of the same entry occur in the same cycle, the read uses the old key. A read in a later cycle uses the new key.
- R9: Reads may be issued on every cycle. Each result carries the key of its own address.
- R10: Asserting reset during operation clears all key entries back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_valid | output | 1 | Descrambled word is on `rd_data` |
| rd_data | output | 32 | Descrambled read word |
| rom_en | output | 1 | Read strobe to the ROM |
| rom_addr | output | ADDR_W | Word address to the ROM |
| rom_data | input | 32 | ROM word, `ROM_LAT` cycles after `rom_en` |
| key_wr_en | input | 1 | Key window write strobe |
| key_wr_addr | input | IDX_W+2 | Byte offset inside the key window |
| key_wr_be | input | 4 | Byte enables; only bit 0 is decoded |
| key_wr_data | input | 32 | Write data; only bits 7:0 are decoded |

## Verification
The bench builds the block with `ROM_LAT` = 2 and keeps the default `ADDR_W` = 17 and `IDX_W` = 8. A ROM latency of two cycles forces the key through one extra delay stage beyond the table read. This exposes any misalignment between key and data when reads stream back to back. The full 17-bit window lets the bench read addresses near the top of the ROM and confirm that they alias onto the same keys as low addresses. The 256-entry table makes the same-entry write/read collision and lane decoding reachable with a few directed cycles.

// File: rtl/rom_key_descrambler.sv
module rom_key_descrambler #(
  parameter int ADDR_W  = 17,
  parameter int IDX_W   = 8,
  parameter int ROM_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              rom_en,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [31:0]       rom_data,
  input  logic              key_wr_en,
  input  logic [IDX_W+1:0]  key_wr_addr,
  input  logic [3:0]        key_wr_be,
  input  logic [31:0]       key_wr_data
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [7:0]         key_mem [ENTRIES];
  logic [7:0]         key_sr  [ROM_LAT];
  logic [ROM_LAT-1:0] vld_sr;

  wire             key_we = key_wr_en & key_wr_be[0];
  wire [IDX_W-1:0] wr_idx = key_wr_addr[IDX_W+1:2];
  wire [IDX_W-1:0] rd_idx = rd_addr[IDX_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{key_wr_addr[1:0], key_wr_be[3:1], key_wr_data[31:8]};

  assign rom_en   = rd_en;
  assign rom_addr = rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) key_mem[i] <= 8'h00;
    end else if (key_we) begin
      key_mem[wr_idx] <= key_wr_data[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_sr <= '0;
      for (int i = 0; i < ROM_LAT; i++) key_sr[i] <= 8'h00;
    end else begin
      vld_sr    <= (vld_sr << 1) | ROM_LAT'(rd_en);
      key_sr[0] <= key_mem[rd_idx];
      for (int i = 1; i < ROM_LAT; i++) key_sr[i] <= key_sr[i-1];
    end
  end

  wire [7:0] key_now = key_sr[ROM_LAT-1];

  assign rd_valid = vld_sr[ROM_LAT-1];
  assign rd_data  = rom_data ^ {key_now, 8'h00, key_now, 8'h00};
endmodule

// File: rtl/rom_key_descrambler_chk.sv
module rom_key_descrambler_chk #(
  parameter int ADDR_W  = 17,
  parameter int IDX_W   = 8,
  parameter int ROM_LAT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [31:0]       rom_data,
  input logic              key_wr_en,
  input logic [3:0]        key_wr_be
);
  logic [ROM_LAT-1:0] en_sh;
  logic               any_key;
  wire  [31:0]        diff = rd_data ^ rom_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_sh   <= '0;
      any_key <= 1'b0;
    end else begin
      en_sh <= (en_sh << 1) | ROM_LAT'(rd_en);
      if (key_wr_en && key_wr_be[0]) any_key <= 1'b1;
    end
  end

  assert_valid_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == en_sh[ROM_LAT-1]);

  assert_clear_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (diff[23:16] == 8'h00 && diff[7:0] == 8'h00));

  assert_key_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (diff[31:24] == diff[15:8]));

  assert_clear_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !any_key) |-> (rd_data == rom_data));

  assert_known_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(rd_valid));
endmodule

bind rom_key_descrambler rom_key_descrambler_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ROM_LAT(ROM_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .rom_data(rom_data), .key_wr_en(key_wr_en),
  .key_wr_be(key_wr_be)
);

// File: tb/test_rom_key_descrambler.sv
module test_rom_key_descrambler;
  localparam int AW  = 17;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          rom_en;
  logic [AW-1:0] rom_addr;
  logic [31:0]   rom_data;
  logic          key_wr_en = 1'b0;
  logic [9:0]    key_wr_addr = '0;
  logic [3:0]    key_wr_be = '0;
  logic [31:0]   key_wr_data = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rom_key_descrambler #(.ADDR_W(AW), .IDX_W(8), .ROM_LAT(LAT)) i_rom_key_descrambler (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_data(rom_data), .key_wr_en(key_wr_en), .key_wr_addr(key_wr_addr),
    .key_wr_be(key_wr_be), .key_wr_data(key_wr_data)
  );

  function automatic logic [31:0] romf(input logic [AW-1:0] a);
    return ({15'h0, a} * 32'h9E3779B1) ^ 32'h5A3CC3A5;
  endfunction

  logic [31:0] rom_pipe [LAT];
  always_ff @(posedge clk) begin
    rom_pipe[0] <= rom_en ? romf(rom_addr) : 32'h0;
    for (int i = 1; i < LAT; i++) rom_pipe[i] <= rom_pipe[i-1];
  end
  assign rom_data = rom_pipe[LAT-1];

  logic [7:0]  kt [256];
  logic [31:0] exp_q [$];
  int          req_q [$];

  task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, 2, rd_data, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic int r = req_q.pop_front();
        check(rd_data === e, r, rd_data, e);
      end
    end
  end

  task automatic cyc(input bit rde, input logic [AW-1:0] a, input bit we,
                     input logic [9:0] wa, input logic [3:0] be,
                     input logic [31:0] wd, input int req);
    @(negedge clk);
    rd_en = rde; rd_addr = a;
    key_wr_en = we; key_wr_addr = wa; key_wr_be = be; key_wr_data = wd;
    if (rde) begin
      exp_q.push_back(romf(a) ^ {kt[a[7:0]], 8'h00, kt[a[7:0]], 8'h00});
      req_q.push_back(req);
    end
    if (we && be[0]) kt[wa[9:2]] = wd[7:0];
    #1;
    if (rde) check(rom_en === 1'b1 && rom_addr === a, 1, {15'h0, rom_addr}, {15'h0, a});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, '0, '0, 0);
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d, input int req);
    cyc(0, '0, 1, {idx, 2'b00}, 4'b0001, d, req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input int req);
    cyc(1, a, 0, '0, '0, '0, req);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  localparam int NV = 8;
  localparam logic [7:0]    V_IDX  [NV] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h33, 8'hA5, 8'h01};
  localparam logic [31:0]   V_DAT  [NV] = '{32'h000000C3, 32'hFFFFFF5A, 32'h00000001, 32'h12345680,
                                            32'hABCDEFFF, 32'h00000033, 32'h0000005A, 32'h000000E7};
  localparam logic [AW-1:0] V_RD   [NV] = '{17'h00000, 17'h00101, 17'h1FF7F, 17'h00080,
                                            17'h1FFFF, 17'h0AB33, 17'h000A5, 17'h00001};

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, 2, 32'h0, 32'h1);
    $display("watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) kt[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(rd_valid === 1'b0, 2, {31'h0, rd_valid}, 32'h0);   // R2 quiet in reset
    check(rom_en === 1'b0, 1, {31'h0, rom_en}, 32'h0);       // R1 no strobe without request
    rst_n = 1'b1;

    rd(17'h00005, 4); rd(17'h1FFFF, 4); idle(LAT + 2);        // R4 clear table

    for (int v = 0; v < NV; v++) begin                       // R3, R5 vector walk
      wr(V_IDX[v], V_DAT[v], 5);
      rd(V_RD[v], 3);
      idle(1);
    end
    idle(LAT + 1);

    wr(8'h10, 32'h0000005A, 5);
    cyc(0, '0, 1, {8'h10, 2'b00}, 4'b1110, 32'hFFFFFFFF, 6); // R6 lane 0 off
    rd(17'h00010, 6);
    cyc(0, '0, 1, {8'h20, 2'b11}, 4'b0001, 32'h0000003C, 6); // R6 low addr bits ignored
    rd(17'h00020, 6);
    rd(17'h00021, 6);
    idle(LAT + 1);

    rd(17'h1FF10, 7); rd(17'h00110, 7); rd(17'h0F020, 7);    // R7 aliasing
    idle(LAT + 1);

    wr(8'h44, 32'h00000011, 8);
    cyc(1, 17'h00044, 1, {8'h44, 2'b00}, 4'b0001, 32'h00000077, 8); // R8 old key
    rd(17'h00044, 8);                                         // R8 new key
    idle(LAT + 1);

    for (int i = 0; i < 20; i++) rd(AW'(17'h1FFF0 + i), 9);   // R9 streaming
    idle(LAT + 2);
    check(exp_q.size() == 0, 2, exp_q.size(), 32'h0);        // R2 one result per request

    @(negedge clk); rst_n = 1'b0;                             // R10 reset clears keys
    for (int i = 0; i < 256; i++) kt[i] = 8'h00;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(17'h00044, 10); rd(17'h00010, 10); rd(17'h000FF, 10);
    idle(LAT + 2);
    check(exp_q.size() == 0, 2, exp_q.size(), 32'h0);
    finish_up();
  end
endmodule